// File: doc/BRIEF.md
# Multi-stage trigger sequencer for a logic analyzer

This block watches the stream of parallel sample words that a logic analyzer captures and decides the moment at which the capture buffer should be told "now". It raises a single-cycle trigger pulse once a programmed chain of conditions has been met in order. Each link of the chain, called a stage, combines a masked level pattern with rising and falling edge requirements on chosen channels. It also carries a minimum-spacing qualifier and an occurrence count. A stage can therefore express a plain level or edge on one line, a bus equal to a constant while a strobe is high, "the Nth rising edge of a line", or "a match no sooner than D samples after the previous stage".

Host software writes each stage's fields and the index of the last active stage through a simple write port, then pulses `arm`. The sequencer walks the stages from 0. After the last one completes it emits the pulse and parks in a fired state until it is armed again. It reports the current stage index and a fired flag so that software can follow its progress. A configuration write while the sequence is running restarts it from stage 0.

Top module: `lat_trig_seq`

## Requirements
- R1: After reset the trigger output is low, the fired flag is low and the stage index is 0, and the sequencer ignores samples until `arm` is pulsed. The reset configuration is: every mask zero, value zero, count 1, delay 0, last stage 0.
- R2: A stage's level condition holds when every sample bit whose level-mask bit is 1 equals the matching value bit. Bits whose level-mask bit is 0 are ignored.
- R3: For each bit set in the rising-edge mask, the stage requires that bit to be 0 in the previously strobed sample and 1 in the current one. The previous-sample register holds 0 after reset.
- R4: For each bit set in the falling-edge mask, the stage requires that bit to be 1 in the previously strobed sample and 0 in the current one.
- R5: A stage completes on the Nth accepted matching sample, where N is its programmed count; a count of 0 behaves as 1.
- R6: Strobed samples are numbered k = 0, 1, 2 from the first one after stage entry; stage entry is `arm` for stage 0, or the sample that completed the previous stage. A match at k below the stage's delay is discarded and does not count toward the occurrence count.
- R7: Completing a stage other than the last advances the stage index by one and clears its occurrence and delay progress. Cycles with `smp_valid` low change nothing, and the sample offered in the same cycle as `arm` is not evaluated.
- R8: Completing the last stage drives `trig` high for exactly one cycle, the cycle after the completing sample is taken, and sets `fired`. While fired, the stage index holds and no further pulse appears until `arm`, which clears `fired`.
- R9: A configuration write while the sequence is running returns it to stage 0 and clears occurrence and delay progress. A write while idle or fired only updates the stored fields.
- R10: `cfg_sel` selects the written field: 0 value, 1 level mask, 2 rising mask, 3 falling mask, 4 count, 5 delay, 6 last-stage index (`cfg_stage` ignored; values beyond the stage count clamp to the top stage). Stages 0 up to the last index run in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start (or restart) the sequence from stage 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stage | input | STG_W | Stage addressed by the write |
| cfg_sel | input | 3 | Field selector (see R10) |
| cfg_data | input | CFG_W | Write data, truncated to the field width |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | WIDTH | Sample word, one bit per channel |
| trig | output | 1 | One-cycle trigger pulse |
| stage_idx | output | STG_W | Stage currently being evaluated |
| fired | output | 1 | Sequence complete, waiting for re-arm |

## Verification
The bound checker watches, on every cycle, the shape of the trigger pulse and its tie to `fired`. It also checks that the stage index moves by at most one step per cycle, stays put on idle cycles, and returns to 0 after `arm` or a configuration write while running. Which sample actually completes a stage cannot be seen by a per-cycle rule. This covers masked-bit don't-cares, edge detection against the previous strobed sample, discarded early matches under a delay, and the Nth-occurrence count. The scoreboard scenarios show these by predicting the exact cycle of every trigger pulse and the stage index after chosen samples.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_FIRED = 2'd2
    } seq_mode_e;

    typedef enum logic [2:0] {
        FLD_VALUE = 3'd0,
        FLD_LMASK = 3'd1,
        FLD_RMASK = 3'd2,
        FLD_FMASK = 3'd3,
        FLD_COUNT = 3'd4,
        FLD_DELAY = 3'd5,
        FLD_LAST  = 3'd6
    } cfg_field_e;

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_seq_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int STAGES = 4,
    parameter int CNT_W  = 12,
    parameter int DLY_W  = 12,
    parameter int CFG_W  = 16,
    parameter int STG_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [STG_W-1:0] cfg_stage,
    input  logic [2:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [STG_W-1:0] rd_stage,
    output logic [WIDTH-1:0] sel_value,
    output logic [WIDTH-1:0] sel_lmask,
    output logic [WIDTH-1:0] sel_rmask,
    output logic [WIDTH-1:0] sel_fmask,
    output logic [CNT_W-1:0] sel_count,
    output logic [DLY_W-1:0] sel_delay,
    output logic [STG_W-1:0] last_stage
);

    typedef struct packed {
        logic [WIDTH-1:0] value;
        logic [WIDTH-1:0] lmask;
        logic [WIDTH-1:0] rmask;
        logic [WIDTH-1:0] fmask;
        logic [CNT_W-1:0] count;
        logic [DLY_W-1:0] delay;
    } stage_cfg_t;

    localparam stage_cfg_t CFG_RESET = '{
        value: '0, lmask: '0, rmask: '0, fmask: '0,
        count: CNT_W'(1), delay: '0
    };

    stage_cfg_t       tbl_d [STAGES];
    stage_cfg_t       tbl_q [STAGES];
    logic [STG_W-1:0] last_d, last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_comb begin
            tbl_d[g] = tbl_q[g];
            if (cfg_we && (cfg_stage == STG_W'(g))) begin
                case (cfg_sel)
                    FLD_VALUE: tbl_d[g].value = cfg_data[WIDTH-1:0];
                    FLD_LMASK: tbl_d[g].lmask = cfg_data[WIDTH-1:0];
                    FLD_RMASK: tbl_d[g].rmask = cfg_data[WIDTH-1:0];
                    FLD_FMASK: tbl_d[g].fmask = cfg_data[WIDTH-1:0];
                    FLD_COUNT: tbl_d[g].count = cfg_data[CNT_W-1:0];
                    FLD_DELAY: tbl_d[g].delay = cfg_data[DLY_W-1:0];
                    default:   tbl_d[g] = tbl_q[g];
                endcase
            end
        end
    end

    always_comb begin
        last_d = last_q;
        if (cfg_we && (cfg_sel == FLD_LAST)) begin
            if (cfg_data >= CFG_W'(STAGES)) last_d = STG_W'(STAGES - 1);
            else                            last_d = cfg_data[STG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) tbl_q[i] <= CFG_RESET;
            last_q <= '0;
        end else begin
            tbl_q  <= tbl_d;
            last_q <= last_d;
        end
    end

    assign sel_value  = tbl_q[rd_stage].value;
    assign sel_lmask  = tbl_q[rd_stage].lmask;
    assign sel_rmask  = tbl_q[rd_stage].rmask;
    assign sel_fmask  = tbl_q[rd_stage].fmask;
    assign sel_count  = tbl_q[rd_stage].count;
    assign sel_delay  = tbl_q[rd_stage].delay;
    assign last_stage = last_q;

endmodule

// File: rtl/trig_match.sv
module trig_match #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [WIDTH-1:0] smp_data,
    input  logic [WIDTH-1:0] value,
    input  logic [WIDTH-1:0] lmask,
    input  logic [WIDTH-1:0] rmask,
    input  logic [WIDTH-1:0] fmask,
    output logic             hit
);

    logic [WIDTH-1:0] prev_d, prev_q;
    logic [WIDTH-1:0] rose, fell;
    logic             level_ok, rise_ok, fall_ok;

    always_comb begin
        prev_d   = smp_valid ? smp_data : prev_q;
        rose     = smp_data & ~prev_q;
        fell     = ~smp_data & prev_q;
        level_ok = ((smp_data ^ value) & lmask) == '0;
        rise_ok  = (rmask & ~rose) == '0;
        fall_ok  = (fmask & ~fell) == '0;
        hit      = smp_valid && level_ok && rise_ok && fall_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/trig_fsm.sv
module trig_fsm
    import trig_seq_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DLY_W = 12,
    parameter int STG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             cfg_we,
    input  logic             smp_valid,
    input  logic             hit,
    input  logic [CNT_W-1:0] count,
    input  logic [DLY_W-1:0] delay,
    input  logic [STG_W-1:0] last_stage,
    output logic [STG_W-1:0] stage_idx,
    output logic             trig,
    output logic             fired
);

    typedef struct packed {
        seq_mode_e        mode;
        logic [STG_W-1:0] stage;
        logic [CNT_W-1:0] occ;
        logic [DLY_W-1:0] tmr;
        logic             trig;
    } seq_t;

    seq_t             s_d, s_q;
    logic [CNT_W:0]   need;
    logic [CNT_W:0]   occ_nx;
    logic             accept, done;

    always_comb begin
        need   = (count == '0) ? (CNT_W+1)'(1) : {1'b0, count};
        occ_nx = {1'b0, s_q.occ} + (CNT_W+1)'(1);
        accept = hit && (s_q.tmr >= delay);
        done   = accept && (occ_nx >= need);

        s_d      = s_q;
        s_d.trig = 1'b0;

        if ((s_q.mode == MODE_RUN) && smp_valid) begin
            if (done) begin
                if (s_q.stage >= last_stage) begin
                    s_d.mode = MODE_FIRED;
                    s_d.trig = 1'b1;
                end else begin
                    s_d.stage = s_q.stage + STG_W'(1);
                    s_d.occ   = '0;
                    s_d.tmr   = '0;
                end
            end else begin
                if (accept)          s_d.occ = occ_nx[CNT_W-1:0];
                if (s_q.tmr != '1)   s_d.tmr = s_q.tmr + DLY_W'(1);
            end
        end

        if (cfg_we && (s_q.mode == MODE_RUN)) begin
            s_d.stage = '0;
            s_d.occ   = '0;
            s_d.tmr   = '0;
            s_d.trig  = 1'b0;
            s_d.mode  = MODE_RUN;
        end

        if (arm) begin
            s_d.mode  = MODE_RUN;
            s_d.stage = '0;
            s_d.occ   = '0;
            s_d.tmr   = '0;
            s_d.trig  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode  <= MODE_IDLE;
            s_q.stage <= '0;
            s_q.occ   <= '0;
            s_q.tmr   <= '0;
            s_q.trig  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stage_idx = s_q.stage;
    assign trig      = s_q.trig;
    assign fired     = (s_q.mode == MODE_FIRED);

endmodule

// File: rtl/lat_trig_seq.sv
module lat_trig_seq #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 4,
    parameter int CNT_W  = 12,
    parameter int DLY_W  = 12,
    parameter int CFG_W  = 16,
    localparam int STG_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             cfg_we,
    input  logic [STG_W-1:0] cfg_stage,
    input  logic [2:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             smp_valid,
    input  logic [WIDTH-1:0] smp_data,
    output logic             trig,
    output logic [STG_W-1:0] stage_idx,
    output logic             fired
);

    logic [WIDTH-1:0] cur_value, cur_lmask, cur_rmask, cur_fmask;
    logic [CNT_W-1:0] cur_count;
    logic [DLY_W-1:0] cur_delay;
    logic [STG_W-1:0] last_stage;
    logic             hit;

    trig_cfg_regs #(
        .WIDTH(WIDTH), .STAGES(STAGES), .CNT_W(CNT_W),
        .DLY_W(DLY_W), .CFG_W(CFG_W), .STG_W(STG_W)
    ) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_stage  (cfg_stage),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .rd_stage   (stage_idx),
        .sel_value  (cur_value),
        .sel_lmask  (cur_lmask),
        .sel_rmask  (cur_rmask),
        .sel_fmask  (cur_fmask),
        .sel_count  (cur_count),
        .sel_delay  (cur_delay),
        .last_stage (last_stage)
    );

    trig_match #(.WIDTH(WIDTH)) i_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .value     (cur_value),
        .lmask     (cur_lmask),
        .rmask     (cur_rmask),
        .fmask     (cur_fmask),
        .hit       (hit)
    );

    trig_fsm #(.CNT_W(CNT_W), .DLY_W(DLY_W), .STG_W(STG_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .cfg_we     (cfg_we),
        .smp_valid  (smp_valid),
        .hit        (hit),
        .count      (cur_count),
        .delay      (cur_delay),
        .last_stage (last_stage),
        .stage_idx  (stage_idx),
        .trig       (trig),
        .fired      (fired)
    );

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
    parameter int STG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             cfg_we,
    input logic             smp_valid,
    input logic             trig,
    input logic [STG_W-1:0] stage_idx,
    input logic             fired
);

    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig); // R8

    AST_TRIG_WITH_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> fired); // R8

    AST_FIRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !arm) |=> (fired && !trig && $stable(stage_idx))); // R8

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!fired && !trig && (stage_idx == '0))); // R8

    AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !fired) |=> (stage_idx == '0) && !trig); // R9

    AST_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !arm && !cfg_we) |=> ($stable(stage_idx) && !trig)); // R7

    AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !cfg_we) |=> ((stage_idx == $past(stage_idx)) ||
                               (stage_idx == STG_W'($past(stage_idx) + 1'b1)))); // R7

endmodule

bind lat_trig_seq trig_seq_chk #(.STG_W(STG_W)) i_trig_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .cfg_we    (cfg_we),
    .smp_valid (smp_valid),
    .trig      (trig),
    .stage_idx (stage_idx),
    .fired     (fired)
);

// File: tb/test_lat_trig_seq.sv
`timescale 1ns/1ps
module test_lat_trig_seq;

    localparam int WIDTH = 16;
    localparam int STG_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm = 1'b0;
    logic             cfg_we = 1'b0;
    logic [STG_W-1:0] cfg_stage = '0;
    logic [2:0]       cfg_sel = '0;
    logic [15:0]      cfg_data = '0;
    logic             smp_valid = 1'b0;
    logic [WIDTH-1:0] smp_data = '0;
    logic             trig;
    logic [STG_W-1:0] stage_idx;
    logic             fired;

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lat_trig_seq i_lat_trig_seq (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_we(cfg_we),
        .cfg_stage(cfg_stage), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .trig(trig), .stage_idx(stage_idx), .fired(fired)
    );

    // Monitor: every pulse must match the head of the expectation queue
    always @(negedge clk) begin
        if (rst_n && trig) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected trigger: got pulse at cycle %0d expected none", cyc);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e != cyc) begin
                    n_bad++;
                    $display("FAIL %s trigger cycle: got %0d expected %0d", t, cyc, e);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_stage(input int exp, input string tag);
        chk(int'(stage_idx) == exp, tag, int'(stage_idx), exp);
    endtask

    task automatic wcfg(input int stg, input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_stage = STG_W'(stg); cfg_sel = 3'(sel); cfg_data = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic stage_cfg(input int stg, input int value, input int lmask,
                             input int rmask, input int fmask, input int count, input int delay);
        wcfg(stg, 0, value);
        wcfg(stg, 1, lmask);
        wcfg(stg, 2, rmask);
        wcfg(stg, 3, fmask);
        wcfg(stg, 4, count);
        wcfg(stg, 5, delay);
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic smp(input int d, input bit expect_trig, input string tag);
        @(negedge clk);
        if (expect_trig) begin
            exp_q.push_back(cyc + 1);
            tag_q.push_back(tag);
        end
        smp_valid = 1'b1;
        smp_data  = WIDTH'(d);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        chk(trig == 1'b0, "R1 trig after reset", int'(trig), 0);
        chk(fired == 1'b0, "R1 fired after reset", int'(fired), 0);
        chk_stage(0, "R1 stage after reset");
        rst_n = 1'b1;
        idle(2);
        // R1: default config would match anything, but not armed yet
        smp(16'h1234, 1'b0, "R1");
        smp(16'h0000, 1'b0, "R1");
        chk(fired == 1'b0, "R1 not armed ignores samples", int'(fired), 0);

        // R2: level pattern with don't-care bits 7:4
        wcfg(0, 6, 0);
        stage_cfg(0, 16'h2005, 16'hFF0F, 0, 0, 1, 0);
        do_arm();
        smp(16'h2004, 1'b0, "R2");
        smp(16'h3005, 1'b0, "R2");
        smp(16'h20F5, 1'b1, "R2");
        chk(fired == 1'b1, "R8 fired after trigger", int'(fired), 1);
        // R8: fired state ignores further matches
        smp(16'h2005, 1'b0, "R8");
        smp(16'h2005, 1'b0, "R8");
        chk(fired == 1'b1, "R8 fired holds", int'(fired), 1);

        // R3: rising edge on bit 3
        stage_cfg(0, 0, 0, 16'h0008, 0, 1, 0);
        do_arm();
        chk(fired == 1'b0, "R8 arm clears fired", int'(fired), 0);
        smp(16'h0000, 1'b0, "R3");
        smp(16'h0008, 1'b1, "R3");
        do_arm();
        smp(16'h0008, 1'b0, "R3");
        smp(16'h0000, 1'b0, "R3");
        smp(16'h0008, 1'b1, "R3");

        // R4: falling edge on bit 0
        stage_cfg(0, 0, 0, 0, 16'h0001, 1, 0);
        do_arm();
        smp(16'h0001, 1'b0, "R4");
        smp(16'h0001, 1'b0, "R4");
        smp(16'h0000, 1'b1, "R4");

        // R5: third rising edge of bit 1
        stage_cfg(0, 0, 0, 16'h0002, 0, 3, 0);
        do_arm();
        smp(16'h0000, 1'b0, "R5");
        smp(16'h0002, 1'b0, "R5");
        smp(16'h0000, 1'b0, "R5");
        smp(16'h0002, 1'b0, "R5");
        chk(fired == 1'b0, "R5 two of three edges", int'(fired), 0);
        smp(16'h0000, 1'b0, "R5");
        smp(16'h0002, 1'b1, "R5");
        // R5: count of zero acts as one
        wcfg(0, 4, 0);
        do_arm();
        smp(16'h0000, 1'b0, "R5");
        smp(16'h0002, 1'b1, "R5");

        // R6: delay 3, count 2, level bit0 high; idle gaps do not count (R7)
        stage_cfg(0, 16'h0001, 16'h0001, 0, 0, 2, 3);
        do_arm();
        smp(16'h0001, 1'b0, "R6");
        idle(4);
        smp(16'h0001, 1'b0, "R6");
        smp(16'h0001, 1'b0, "R6");
        chk(fired == 1'b0, "R6 early matches discarded", int'(fired), 0);
        smp(16'h0001, 1'b0, "R6");
        smp(16'h0001, 1'b1, "R6");

        // R10/R7: three-stage chain
        wcfg(0, 6, 2);
        stage_cfg(0, 16'h0011, 16'h00FF, 0, 0, 1, 0);
        stage_cfg(1, 0, 0, 16'h0100, 0, 2, 0);
        stage_cfg(2, 16'hABCD, 16'hFFFF, 0, 0, 1, 2);
        do_arm();
        chk_stage(0, "R7 armed at stage 0");
        smp(16'h0000, 1'b0, "R7");
        chk_stage(0, "R7 no match keeps stage");
        smp(16'h0011, 1'b0, "R7");
        chk_stage(1, "R7 advance to stage 1");
        smp(16'h0111, 1'b0, "R7");
        chk_stage(1, "R5 stage 1 first edge");
        smp(16'h0011, 1'b0, "R7");
        smp(16'h0111, 1'b0, "R7");
        chk_stage(2, "R10 advance to stage 2");
        smp(16'hABCD, 1'b0, "R6");
        smp(16'hABCD, 1'b0, "R6");
        chk_stage(2, "R6 stage 2 waiting delay");
        smp(16'hABCD, 1'b1, "R10");
        chk_stage(2, "R8 stage holds after fire");
        chk(fired == 1'b1, "R10 chain fired", int'(fired), 1);

        // R9: config write while running restarts and clears progress
        do_arm();
        smp(16'h0011, 1'b0, "R9");
        smp(16'h0111, 1'b0, "R9");
        chk_stage(1, "R9 before write");
        wcfg(2, 5, 0);
        chk_stage(0, "R9 write restarts");
        smp(16'h0111, 1'b0, "R9");
        chk_stage(1, "R9 stage 0 again");
        smp(16'h0011, 1'b0, "R9");
        smp(16'h0111, 1'b0, "R9");
        chk_stage(1, "R9 occurrence cleared");
        smp(16'h0011, 1'b0, "R9");
        smp(16'h0111, 1'b0, "R9");
        chk_stage(2, "R9 stage 2 reached");
        smp(16'hABCD, 1'b1, "R9");

        idle(4);
        while (exp_q.size() != 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            n_bad++;
            $display("FAIL %s missing trigger: got none expected cycle %0d", t, e);
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule